// File: doc/BRIEF.md
# Eight-bit accumulator ALU

This block is the combinational datapath core of a small accumulator processor. It takes two operands, a three-bit operation code, a compare control and a carry input. It returns a result word, a carry output and a zero flag. No clock or storage is involved. The surrounding processor holds the flags and decides which results to write back.

All four arithmetic operations share one adder. A selector in front of the adder's second input picks B, the complement of B, all zeros or all ones. It also picks the adder's carry input: the external carry passes through for add and subtract, and is forced for increment and decrement.

In subtraction the carry acts as an inverted borrow. Multi-byte add and subtract chains therefore work once the caller presets the carry. Compare is a subtraction whose carry is forced high; the caller keeps the flags and discards the result. A left shift through the carry has no separate path: the caller adds the accumulator to itself.

Top module: `alu_accum`

## Requirements
- R1: With op_sel = 3'b000 (add), {carry_out, result} equals a_in + b_in + carry_in.
- R2: With op_sel = 3'b001 (subtract) and cmp_en = 0, result equals a_in + ~b_in + carry_in modulo 256, so a clear carry_in yields a_in - b_in - 1. carry_out is 1 when no borrow occurred and 0 when one did.
- R3: With op_sel = 3'b010 (increment), result equals a_in + 1 and carry_out is 1 only when a_in is 8'hFF. carry_in has no effect.
- R4: With op_sel = 3'b011 (decrement), result equals a_in - 1 and carry_out is 0 only when a_in is 8'h00. carry_in has no effect.
- R5: With op_sel = 3'b001 and cmp_en = 1, the adder carry is forced to 1 whatever carry_in is. result equals a_in - b_in, and carry_out is 1 exactly when a_in >= b_in (unsigned).
- R6: cmp_en has no effect on result or carry_out for any op_sel other than 3'b001.
- R7: With op_sel = 3'b100, 3'b101 or 3'b110, result is the bitwise AND, OR or XOR of a_in and b_in respectively, and carry_out equals carry_in.
- R8: With op_sel = 3'b111 (rotate right through carry), result is {carry_in, a_in[7:1]} and carry_out is a_in[0].
- R9: zero_flag is 1 exactly when all bits of result are 0, for every operation.
- R10: Addition with a_in equal to b_in gives a left shift through the carry: result is {a_in[6:0], carry_in} and carry_out is a_in[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| op_sel | input | 3 | Operation code; bit 2 selects the logic path |
| cmp_en | input | 1 | Compare control; forces the subtract carry high |
| carry_in | input | 1 | Carry, or inverted borrow for subtraction |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Carry, or inverted borrow for subtraction |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The bench sweeps every operand pair for add, subtract and the three bitwise operations, with both carry values. A swapped inversion or an ignored carry on the B path would show up there as results off by one, or as borrow flags reversed at the a_in = b_in boundary.

Increment and decrement are driven with the opposite external carry and across the 8'hFF and 8'h00 wrap points. A design that forwarded carry_in, or forced the wrong constant, would be off by one or would report the wrong wrap carry.

Compare is run with carry_in clear, and again on other operation codes, to catch a forcing that is missing or that leaks into other operations. Rotate, the add-to-itself left shift and the zero flag are checked at their edge bits, so any misrouted bit 0 or bit 7 is exposed.

// File: rtl/alu_accum_pkg.sv
package alu_accum_pkg;

   // Operation codes; bit 2 chooses logic path over arithmetic path.
   typedef enum logic [2:0] {
      OP_ADC = 3'b000,
      OP_SBC = 3'b001,
      OP_INC = 3'b010,
      OP_DEC = 3'b011,
      OP_AND = 3'b100,
      OP_OR  = 3'b101,
      OP_XOR = 3'b110,
      OP_ROR = 3'b111
   } alu_op_e;

   // Source picked for the adder's second input.
   typedef enum logic [1:0] {
      BSRC_PASS = 2'b00,
      BSRC_INV  = 2'b01,
      BSRC_ZERO = 2'b10,
      BSRC_ONES = 2'b11
   } bsrc_e;

   // Adder implementation variants.
   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_INFER  = 1;

endpackage

// File: rtl/alu_b_select.sv
module alu_b_select
   import alu_accum_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       arith_op,
   input  logic [WIDTH-1:0] b_in,
   input  logic             cmp_en,
   input  logic             carry_in,
   output logic [WIDTH-1:0] b_eff,
   output logic             c_eff
);

   bsrc_e src;

   // Low two opcode bits pick both the B source and the carry policy.
   always_comb begin
      unique case (arith_op)
         2'b00: begin src = BSRC_PASS; c_eff = carry_in;                end
         2'b01: begin src = BSRC_INV;  c_eff = cmp_en ? 1'b1 : carry_in; end
         2'b10: begin src = BSRC_ZERO; c_eff = 1'b1;                    end
         default: begin src = BSRC_ONES; c_eff = 1'b0;                  end
      endcase
   end

   always_comb begin
      unique case (src)
         BSRC_PASS: b_eff = b_in;
         BSRC_INV:  b_eff = ~b_in;
         BSRC_ZERO: b_eff = '0;
         default:   b_eff = '1;
      endcase
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder
   import alu_accum_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int STYLE = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   generate
      if (STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];
      end else if (STYLE == ADDER_INFER) begin : g_infer
         logic [WIDTH:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[WIDTH-1:0];
         assign cout = full[WIDTH];
      end else begin : g_bad_style
         $error("alu_adder: unknown STYLE value");
      end
   endgenerate

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       logic_op,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             carry_in,
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   always_comb begin
      cout = carry_in;
      unique case (logic_op)
         2'b00: res = a_in & b_in;
         2'b01: res = a_in | b_in;
         2'b10: res = a_in ^ b_in;
         default: begin
            res  = {carry_in, a_in[WIDTH-1:1]};
            cout = a_in[0];
         end
      endcase
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] word,
   output logic             is_zero
);

   assign is_zero = ~|word;

endmodule

// File: rtl/alu_accum.sv
module alu_accum
   import alu_accum_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [2:0]       op_sel,
   input  logic             cmp_en,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero_flag
);

   localparam int PATH_BIT = 2;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_accum: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] b_eff;
   logic             c_eff;
   logic [WIDTH-1:0] arith_res;
   logic             arith_co;
   logic [WIDTH-1:0] logic_res;
   logic             logic_co;

   alu_b_select #(.WIDTH(WIDTH)) u_bsel (
      .arith_op (op_sel[1:0]),
      .b_in     (b_in),
      .cmp_en   (cmp_en),
      .carry_in (carry_in),
      .b_eff    (b_eff),
      .c_eff    (c_eff)
   );

   alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .x    (a_in),
      .y    (b_eff),
      .cin  (c_eff),
      .sum  (arith_res),
      .cout (arith_co)
   );

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .logic_op (op_sel[1:0]),
      .a_in     (a_in),
      .b_in     (b_in),
      .carry_in (carry_in),
      .res      (logic_res),
      .cout     (logic_co)
   );

   always_comb begin
      if (op_sel[PATH_BIT]) begin
         result    = logic_res;
         carry_out = logic_co;
      end else begin
         result    = arith_res;
         carry_out = arith_co;
      end
   end

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .word    (result),
      .is_zero (zero_flag)
   );

endmodule

// File: rtl/alu_accum_chk.sv
module alu_accum_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [2:0]       op_sel,
   input logic             cmp_en,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             zero_flag
);

   logic [WIDTH:0] wide_a;
   logic [WIDTH:0] wide_b;
   logic [WIDTH:0] got;

   assign wide_a = {1'b0, a_in};
   assign wide_b = {1'b0, b_in};
   assign got    = {carry_out, result};

   always_comb begin
      p_zero_matches_result_r9: assert (zero_flag == (result == '0))
         else $error("zero flag disagrees with result");
      if (op_sel == 3'b000)
         p_add_sum_r1: assert (got == wide_a + wide_b + {{WIDTH{1'b0}}, carry_in})
            else $error("add result wrong");
      if (op_sel == 3'b010)
         p_inc_sum_r3: assert (got == wide_a + 1'b1)
            else $error("increment result wrong");
      if (op_sel == 3'b011)
         p_dec_sum_r4: assert (result == a_in - 1'b1 && carry_out == (a_in != '0))
            else $error("decrement result wrong");
      if (op_sel == 3'b001 && cmp_en)
         p_cmp_forced_r5: assert (result == a_in - b_in && carry_out == (a_in >= b_in))
            else $error("compare result wrong");
      if (op_sel == 3'b100 || op_sel == 3'b101 || op_sel == 3'b110)
         p_logic_keeps_carry_r7: assert (carry_out == carry_in)
            else $error("logic op changed carry");
      if (op_sel == 3'b111)
         p_ror_edges_r8: assert (carry_out == a_in[0] && result[WIDTH-1] == carry_in)
            else $error("rotate edge bits wrong");
   end

endmodule

bind alu_accum alu_accum_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_accum.sv
module tb_alu_accum;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int WATCHDOG   = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [2:0]   op_sel = '0;
   logic         cmp_en = 1'b0;
   logic         carry_in = 1'b0;
   logic [W-1:0] result;
   logic         carry_out;
   logic         zero_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_accum #(.WIDTH(W)) dut (
      .a_in      (a_in),
      .b_in      (b_in),
      .op_sel    (op_sel),
      .cmp_en    (cmp_en),
      .carry_in  (carry_in),
      .result    (result),
      .carry_out (carry_out),
      .zero_flag (zero_flag)
   );

   // Reference from the requirements: returns {carry, result} as an int.
   function automatic int model(int a, int b, int op, bit cmp, bit cin);
      int s;
      int c;
      case (op)
         0: s = a + b + cin;
         1: begin c = cmp ? 1 : cin; s = a + (255 - b) + c; end
         2: s = a + 1;
         3: s = a + 255;
         4: s = (cin << 8) | (a & b);
         5: s = (cin << 8) | (a | b);
         6: s = (cin << 8) | (a ^ b);
         default: s = ((a & 1) << 8) | (cin << 7) | (a >> 1);
      endcase
      return s & 511;
   endfunction

   task automatic drive(int a, int b, int op, bit cmp, bit cin);
      a_in = W'(a); b_in = W'(b); op_sel = 3'(op); cmp_en = cmp; carry_in = cin;
      #1;
   endtask

   task automatic check(string tag, int exp);
      int got;
      bit ez;
      got = {23'd0, carry_out, result};
      ez  = ((exp & 255) == 0);
      checks++;
      if (got != exp || zero_flag != ez) begin
         errors++;
         $display("FAIL %s: a=%h b=%h op=%0d cmp=%0b cin=%0b got co/res=%h z=%0b exp co/res=%h z=%0b",
                  tag, a_in, b_in, op_sel, cmp_en, carry_in, got, zero_flag, exp, ez);
      end
   endtask

   task automatic t_reset_state();
      drive(0, 0, 0, 0, 0);
      check("R9 reset", 9'h000 | 0);
      if (zero_flag !== 1'b1) begin
         errors++;
         $display("FAIL R9 reset zero: got %0b exp 1", zero_flag);
      end
      checks++;
   endtask

   task automatic t_add_sweep();
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++) begin
               drive(a, b, 0, 0, c[0]);
               check("R1 add", model(a, b, 0, 0, c[0]));
            end
   endtask

   task automatic t_sub_sweep();
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++) begin
               drive(a, b, 1, 0, c[0]);
               check("R2 sub", model(a, b, 1, 0, c[0]));
            end
      // No-borrow and borrow boundaries spelled out.
      drive(8'h10, 8'h10, 1, 0, 1); check("R2 equal no borrow", 9'h100);
      drive(8'h10, 8'h11, 1, 0, 1); check("R2 borrow", 9'h0FF);
      drive(8'h10, 8'h10, 1, 0, 0); check("R2 clear carry minus one", 9'h0FF);
   endtask

   task automatic t_inc_dec();
      for (int a = 0; a < 256; a++)
         for (int c = 0; c < 2; c++) begin
            drive(a, 8'h5A, 2, 0, c[0]);
            check("R3 inc", model(a, 0, 2, 0, 0));
            drive(a, 8'hA5, 3, 0, c[0]);
            check("R4 dec", model(a, 0, 3, 0, 0));
         end
      drive(8'hFF, 0, 2, 0, 0); check("R3 wrap", 9'h100);
      drive(8'h00, 0, 3, 0, 1); check("R4 wrap", 9'h0FF);
   endtask

   task automatic t_compare();
      for (int a = 0; a < 256; a += 3)
         for (int b = 0; b < 256; b += 5) begin
            drive(a, b, 1, 1, 0);
            check("R5 compare", (((a >= b) ? 256 : 0) | ((a - b) & 255)));
         end
      drive(8'h42, 8'h42, 1, 1, 0); check("R5 compare equal", 9'h100);
   endtask

   task automatic t_cmp_ignored();
      for (int op = 0; op < 8; op++) begin
         if (op == 1) continue;
         for (int c = 0; c < 2; c++) begin
            drive(8'h81, 8'h7E, op, 1, c[0]);
            check("R6 cmp ignored", model(8'h81, 8'h7E, op, 0, c[0]));
         end
      end
   endtask

   task automatic t_logic_sweep();
      for (int op = 4; op < 7; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) begin
               drive(a, b, op, 0, a[0] ^ b[1]);
               check("R7 logic", model(a, b, op, 0, a[0] ^ b[1]));
            end
   endtask

   task automatic t_rotate();
      for (int a = 0; a < 256; a++)
         for (int c = 0; c < 2; c++) begin
            drive(a, 8'h33, 7, 0, c[0]);
            check("R8 rotate", model(a, 0, 7, 0, c[0]));
         end
      drive(8'h01, 0, 7, 0, 0); check("R8 bit0 to carry", 9'h100);
      drive(8'h00, 0, 7, 0, 1); check("R8 carry to bit7", 9'h080);
   endtask

   task automatic t_shift_left();
      for (int a = 0; a < 256; a++)
         for (int c = 0; c < 2; c++) begin
            drive(a, a, 0, 0, c[0]);
            check("R10 shift left", (((a >> 7) & 1) << 8) | ((a << 1) & 254) | c);
         end
   endtask

   task automatic t_zero_flag();
      drive(8'h80, 8'h80, 0, 0, 0); check("R9 zero on add wrap", 9'h100);
      drive(8'hF0, 8'h0F, 4, 0, 1); check("R9 zero on and", 9'h100);
      drive(8'h01, 0, 3, 0, 0);     check("R9 zero on dec", 9'h100);
      drive(8'h01, 0, 7, 0, 0);     check("R9 zero on rotate", 9'h100);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_add_sweep();
      t_sub_sweep();
      t_inc_dec();
      t_compare();
      t_cmp_ignored();
      t_logic_sweep();
      t_rotate();
      t_shift_left();
      t_zero_flag();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, got timeout exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule